// File: doc/BRIEF.md
# Continuous burst link transmitter

This block is the sending half of a link-layer controller. It empties a transmit FIFO of fixed-size packets onto a word-wide physical link. Each frame starts with a header word. After the header has gone out, the block requests the medium and waits for a grant. It then streams the data words of the packets it counted when it built the header.

The length of a frame is not fixed when the header leaves. When a segment of packets has been sent and the FIFO still holds whole packets, the block sends a continue word that carries the next segment length. It then keeps going on the same grant. Packets written while a burst is running can therefore join it without a second arbitration. When the FIFO is empty at a segment boundary, the block closes the frame with an end word and releases the medium.

A statistics counter counts medium requests. It shows whether back-to-back traffic went out under a single arbitration.

Top module: `cbt_link_tx`

## Requirements
- R1: While reset is asserted, and after it, tx_valid, arb_req and fifo_rd are low, and arb_count is zero.
- R2: When the block is idle and fifo_count (whole packets waiting) is non-zero at a clock edge, tx carries a header word in the next cycle. The header has tx_tag 2'b01, and its tx_data holds the segment length in packets, zero-extended. arb_req is still low in that cycle.
- R3: arb_req goes high in the cycle after the header word. It then stays high up to the end word. fifo_rd is first asserted in the cycle after the first clock edge at which arb_req and arb_gnt are both high.
- R4: A header or continue word is followed by exactly length × PKT_WORDS data words. Each data word has tx_tag 2'b00 and leaves in FIFO order, one cycle after the cycle in which it was read. The length is fixed at the header or continue word, so packets that arrive later do not change it.
- R5: In the cycle after the last data word of a segment, if fifo_count is non-zero, tx carries a continue word. The continue word has tx_tag 2'b10 and tx_data holding the new segment length. arb_req stays high and no new request is made.
- R6: In the cycle after the last data word of a segment, if fifo_count is zero, tx carries an end word with tx_tag 2'b11 and tx_data zero. arb_req is low in that same cycle.
- R7: Every segment length is the smaller of fifo_count and MAX_BURST.
- R8: arb_count increases by exactly one in each cycle in which arb_req rises, and holds otherwise. A frame extended by continue words therefore adds one.
- R9: fifo_rd is high only while data words are being read under a grant. tx_valid is low, with tag and data zero, whenever no header, data, continue or end word is being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_valid | input | 1 | FIFO head word is valid |
| fifo_data | input | DATA_W | FIFO head word (show-ahead) |
| fifo_count | input | CNT_W | Whole packets waiting in the FIFO |
| fifo_rd | output | 1 | Pops the FIFO head word at the clock edge |
| arb_req | output | 1 | Medium request |
| arb_gnt | input | 1 | Medium grant |
| tx_valid | output | 1 | A link word is presented |
| tx_tag | output | 2 | Word type: 00 data, 01 header, 10 continue, 11 end |
| tx_data | output | DATA_W | Link word |
| arb_count | output | STAT_W | Number of medium requests made since reset |

## Verification
- **Header:** due one cycle after the edge that sees packets while the block is idle.
- **Request:** rises one cycle after the header.
- **FIFO reads:** fifo_rd follows the first edge with request and grant both high by one cycle.
- **Data words:** each trails its read by one cycle.
- **Continue or end word:** due one cycle after the last data word of a segment.

The bench drives every input on the falling edge. A behavioural queue model advances once per cycle with those inputs, so its prediction always targets the next rising edge. The next falling edge compares every output against that prediction, which keeps each check on the cycle in which its result is due.

// File: rtl/cbt_pkg.sv
// Shared types for the continuous burst link transmitter.
package cbt_pkg;

    // Word type presented with every link word.
    typedef enum logic [1:0] {
        TAG_DATA = 2'b00,
        TAG_HDR  = 2'b01,
        TAG_CONT = 2'b10,
        TAG_END  = 2'b11
    } cbt_tag_e;

    // Controller phases.
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARB,
        ST_XFER,
        ST_BND
    } cbt_state_e;

endpackage

// File: rtl/cbt_seg_len.sv
// Segment length: the number of waiting whole packets capped at MAX_BURST.
// Assumes the count never exceeds what CNT_W can hold.
module cbt_seg_len #(
    parameter int CNT_W     = 8,
    parameter int MAX_BURST = 8,
    parameter int LEN_W     = 4
) (
    input  logic [CNT_W-1:0] count,
    output logic [LEN_W-1:0] len
);

    logic capped;

    // Pick the cap or the raw count.
    always_comb begin
        capped = (32'(count) > MAX_BURST);
        len    = capped ? LEN_W'(MAX_BURST) : LEN_W'(count);
    end

endmodule

// File: rtl/cbt_arb_stats.sv
// Counts medium requests; one pulse on inc adds one. Wraps at 2**STAT_W.
module cbt_arb_stats #(
    parameter int STAT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    output logic [STAT_W-1:0] count
);

    // Request counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + STAT_W'(1);
        end
    end

endmodule

// File: rtl/cbt_tx_out.sv
// Output register for the link word. Data words pass the FIFO head through;
// control words carry the segment length (zero for the end word).
// Idle cycles present all zeros.
module cbt_tx_out
    import cbt_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              emit_valid,
    input  cbt_tag_e          emit_tag,
    input  logic [LEN_W-1:0]  emit_len,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              tx_valid,
    output logic [1:0]        tx_tag,
    output logic [DATA_W-1:0] tx_data
);

    // Register one link word per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_tag   <= 2'b00;
            tx_data  <= '0;
        end else if (emit_valid) begin
            tx_valid <= 1'b1;
            tx_tag   <= emit_tag;
            tx_data  <= (emit_tag == TAG_DATA) ? fifo_data : DATA_W'(emit_len);
        end else begin
            tx_valid <= 1'b0;
            tx_tag   <= 2'b00;
            tx_data  <= '0;
        end
    end

endmodule

// File: rtl/cbt_tx_fsm.sv
// Frame sequencer. Sends the header first, then requests the medium. Once
// granted it reads seg_len packets, and at each boundary either continues
// with a fresh segment or ends the frame. Assumes fifo_count counts whole
// packets not yet started and that the grant stays up while requested.
module cbt_tx_fsm
    import cbt_pkg::*;
#(
    parameter int PKT_WORDS = 4,
    parameter int CNT_W     = 8,
    parameter int LEN_W     = 4,
    parameter int WCNT_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_valid,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic [LEN_W-1:0]  seg_len,
    input  logic              arb_gnt,
    output logic              fifo_rd,
    output logic              arb_req,
    output logic              arb_start,
    output logic              emit_valid,
    output cbt_tag_e          emit_tag,
    output logic [LEN_W-1:0]  emit_len
);

    cbt_state_e        state_q;
    logic              req_q;
    logic [WCNT_W-1:0] words_q;
    logic [WCNT_W-1:0] seg_words;
    logic              has_pkt;

    // Words in the segment being opened and whether packets wait.
    always_comb begin
        seg_words = WCNT_W'(seg_len) * WCNT_W'(PKT_WORDS);
        has_pkt   = (fifo_count != '0);
    end

    // Word selection and FIFO pop for the current phase.
    always_comb begin
        emit_valid = 1'b0;
        emit_tag   = TAG_DATA;
        emit_len   = '0;
        fifo_rd    = 1'b0;
        arb_start  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (has_pkt) begin
                    emit_valid = 1'b1;
                    emit_tag   = TAG_HDR;
                    emit_len   = seg_len;
                end
            end
            ST_ARB: begin
                arb_start = !req_q;
            end
            ST_XFER: begin
                fifo_rd    = fifo_valid;
                emit_valid = fifo_valid;
                emit_tag   = TAG_DATA;
            end
            ST_BND: begin
                emit_valid = 1'b1;
                emit_tag   = has_pkt ? TAG_CONT : TAG_END;
                emit_len   = has_pkt ? seg_len : '0;
            end
            default: ;
        endcase
    end

    // Phase, request and remaining-word registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            req_q   <= 1'b0;
            words_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (has_pkt) begin
                        words_q <= seg_words;
                        state_q <= ST_ARB;
                    end
                end
                ST_ARB: begin
                    req_q <= 1'b1;
                    if (req_q && arb_gnt) begin
                        state_q <= ST_XFER;
                    end
                end
                ST_XFER: begin
                    if (fifo_valid) begin
                        words_q <= words_q - WCNT_W'(1);
                        if (words_q == WCNT_W'(1)) begin
                            state_q <= ST_BND;
                        end
                    end
                end
                ST_BND: begin
                    if (has_pkt) begin
                        words_q <= seg_words;
                        state_q <= ST_XFER;
                    end else begin
                        req_q   <= 1'b0;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign arb_req = req_q;

endmodule

// File: rtl/cbt_link_tx.sv
// Continuous burst link transmitter top. Wires the segment-length cap, the
// frame sequencer, the output register and the request counter. Assumes a
// show-ahead FIFO whose count covers whole packets only.
module cbt_link_tx
    import cbt_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int PKT_WORDS = 4,
    parameter int MAX_BURST = 8,
    parameter int CNT_W     = 8,
    parameter int STAT_W    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_valid,
    input  logic [DATA_W-1:0] fifo_data,
    input  logic [CNT_W-1:0]  fifo_count,
    output logic              fifo_rd,
    output logic              arb_req,
    input  logic              arb_gnt,
    output logic              tx_valid,
    output logic [1:0]        tx_tag,
    output logic [DATA_W-1:0] tx_data,
    output logic [STAT_W-1:0] arb_count
);

    localparam int LEN_W  = $clog2(MAX_BURST + 1);
    localparam int WCNT_W = $clog2(MAX_BURST * PKT_WORDS + 1);

    logic [LEN_W-1:0] seg_len;
    logic             arb_start;
    logic             emit_valid;
    cbt_tag_e         emit_tag;
    logic [LEN_W-1:0] emit_len;

    cbt_seg_len #(
        .CNT_W(CNT_W), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W)
    ) u_len (
        .count(fifo_count),
        .len  (seg_len)
    );

    cbt_tx_fsm #(
        .PKT_WORDS(PKT_WORDS), .CNT_W(CNT_W), .LEN_W(LEN_W), .WCNT_W(WCNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_valid(fifo_valid),
        .fifo_count(fifo_count),
        .seg_len   (seg_len),
        .arb_gnt   (arb_gnt),
        .fifo_rd   (fifo_rd),
        .arb_req   (arb_req),
        .arb_start (arb_start),
        .emit_valid(emit_valid),
        .emit_tag  (emit_tag),
        .emit_len  (emit_len)
    );

    cbt_tx_out #(
        .DATA_W(DATA_W), .LEN_W(LEN_W)
    ) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit_valid(emit_valid),
        .emit_tag  (emit_tag),
        .emit_len  (emit_len),
        .fifo_data (fifo_data),
        .tx_valid  (tx_valid),
        .tx_tag    (tx_tag),
        .tx_data   (tx_data)
    );

    cbt_arb_stats #(
        .STAT_W(STAT_W)
    ) u_stats (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (arb_start),
        .count(arb_count)
    );

endmodule

// File: rtl/cbt_link_tx_chk.sv
// Protocol checker for cbt_link_tx, attached by bind. Observes ports only.
module cbt_link_tx_chk
    import cbt_pkg::*;
#(
    parameter int STAT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fifo_rd,
    input logic              arb_req,
    input logic              tx_valid,
    input logic [1:0]        tx_tag,
    input logic [STAT_W-1:0] arb_count
);

    // A header is followed by the medium request.
    assert_req_after_hdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_tag == TAG_HDR) |=> arb_req);

    // Every FIFO read yields a data word one cycle later.
    assert_read_to_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |=> (tx_valid && tx_tag == TAG_DATA));

    // A continue word never drops the medium.
    assert_cont_keeps_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_tag == TAG_CONT) |-> arb_req);

    // The request falls only together with an end word.
    assert_release_on_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(arb_req) |-> (tx_valid && tx_tag == TAG_END));

    // The counter steps exactly on a request rise.
    assert_count_on_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_req) |-> (arb_count == $past(arb_count) + STAT_W'(1)));

    // The counter is otherwise steady.
    assert_count_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(arb_req) |-> $stable(arb_count));

    // Reads happen only under a request.
    assert_read_needs_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> arb_req);

endmodule

bind cbt_link_tx cbt_link_tx_chk #(.STAT_W(STAT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fifo_rd  (fifo_rd),
    .arb_req  (arb_req),
    .tx_valid (tx_valid),
    .tx_tag   (tx_tag),
    .arb_count(arb_count)
);

// File: tb/sim_cbt_link_tx.sv
`timescale 1ns/1ps
module sim_cbt_link_tx;

    localparam int DW = 32;
    localparam int PW = 4;
    localparam int MB = 8;
    localparam int CW = 8;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_valid = 1'b0;
    logic [DW-1:0] fifo_data = '0;
    logic [CW-1:0] fifo_count = '0;
    logic          fifo_rd;
    logic          arb_req;
    logic          arb_gnt = 1'b0;
    logic          tx_valid;
    logic [1:0]    tx_tag;
    logic [DW-1:0] tx_data;
    logic [SW-1:0] arb_count;

    always #2.5 clk = ~clk;

    cbt_link_tx #(
        .DATA_W(DW), .PKT_WORDS(PW), .MAX_BURST(MB), .CNT_W(CW), .STAT_W(SW)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .fifo_valid(fifo_valid), .fifo_data(fifo_data),
        .fifo_count(fifo_count), .fifo_rd(fifo_rd), .arb_req(arb_req),
        .arb_gnt(arb_gnt), .tx_valid(tx_valid), .tx_tag(tx_tag),
        .tx_data(tx_data), .arb_count(arb_count)
    );

    int checks = 0;
    int failures = 0;

    // Bench FIFO and reference model state.
    logic [DW-1:0] q[$];
    int  seq = 0;
    int  pend_push = 0;
    bit  pop_pend = 0;
    int  m_st = 0;
    bit  m_req = 0;
    int  m_words = 0;
    int  m_arb = 0;
    int  gnt_wait = 0;
    int  req_age = 0;
    bit            e_valid = 0;
    logic [1:0]    e_tag = 0;
    logic [DW-1:0] e_data = 0;
    logic [DW-1:0] last_hdr = 0;
    int  cont_seen = 0;

    task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic string word_req();
        if (!e_valid) return "R9 idle word";
        case (e_tag)
            2'b01:   return "R2 header word";
            2'b10:   return "R5 continue word";
            2'b11:   return "R6 end word";
            default: return "R4 data word";
        endcase
    endfunction

    // Reference model: predicts outputs after the coming rising edge.
    task automatic step();
        int cnt;
        int len;
        cnt = q.size() / PW;
        len = (cnt > MB) ? MB : cnt;
        e_valid = 0; e_tag = 0; e_data = 0;
        case (m_st)
            0: if (cnt > 0) begin
                e_valid = 1; e_tag = 2'b01; e_data = DW'(len);
                m_words = len * PW; m_st = 1;
            end
            1: if (m_req && arb_gnt) m_st = 2;
               else if (!m_req) begin m_req = 1; m_arb++; end
            2: begin
                e_valid = 1; e_tag = 2'b00; e_data = q[0];
                pop_pend = 1; m_words--;
                if (m_words == 0) m_st = 3;
            end
            default: if (cnt > 0) begin
                e_valid = 1; e_tag = 2'b10; e_data = DW'(len);
                m_words = len * PW; m_st = 2;
            end else begin
                e_valid = 1; e_tag = 2'b11; e_data = 0;
                m_req = 0; m_st = 0;
            end
        endcase
    endtask

    // One cycle: compare, update FIFO, drive inputs, predict.
    task automatic tick();
        @(negedge clk);
        if (rst_n) begin
            chk(tx_valid === e_valid, {word_req(), " tx_valid"}, 64'(tx_valid), 64'(e_valid));
            chk(tx_tag === e_tag, {word_req(), " tx_tag"}, 64'(tx_tag), 64'(e_tag));
            chk(tx_data === e_data, {word_req(), " tx_data"}, 64'(tx_data), 64'(e_data));
            chk(arb_req === m_req, "R3 arb_req", 64'(arb_req), 64'(m_req));
            chk(arb_count === SW'(m_arb), "R8 arb_count", 64'(arb_count), 64'(m_arb));
            if (tx_valid && tx_tag == 2'b01) last_hdr = tx_data;
            if (tx_valid && tx_tag == 2'b10) cont_seen++;
        end
        if (pop_pend) begin
            void'(q.pop_front());
            pop_pend = 0;
        end
        for (int i = 0; i < pend_push * PW; i++) begin
            q.push_back(32'hC0DE_0000 + DW'(seq));
            seq++;
        end
        pend_push = 0;
        if (m_req) req_age++; else req_age = 0;
        arb_gnt    = m_req && (req_age > gnt_wait);
        fifo_valid = (q.size() > 0);
        fifo_data  = (q.size() > 0) ? q[0] : '0;
        fifo_count = CW'(q.size() / PW);
        #1;
        if (rst_n) begin
            chk(fifo_rd === (m_st == 2), "R3 R9 fifo_rd", 64'(fifo_rd), 64'(m_st == 2));
            step();
        end
    endtask

    task automatic run_idle();
        do tick(); while (!(m_st == 0 && q.size() == 0 && !e_valid && pend_push == 0));
        tick();
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [SW-1:0] a0;
        int c0;
        repeat (4) tick();
        // R1: reset values.
        chk(tx_valid === 1'b0, "R1 tx_valid", 64'(tx_valid), 0);
        chk(arb_req === 1'b0, "R1 arb_req", 64'(arb_req), 0);
        chk(fifo_rd === 1'b0, "R1 fifo_rd", 64'(fifo_rd), 0);
        chk(arb_count === '0, "R1 arb_count", 64'(arb_count), 0);
        rst_n = 1'b1;
        repeat (3) tick();

        // Single packet, immediate grant.
        a0 = arb_count; c0 = cont_seen; gnt_wait = 0; pend_push = 1;
        run_idle();
        chk(last_hdr == 1, "R2 header length", 64'(last_hdr), 1);
        chk(arb_count - a0 == 1, "R8 one request", 64'(arb_count - a0), 1);
        chk(cont_seen == c0, "R6 no continue", 64'(cont_seen - c0), 0);

        // Three packets, slow grant.
        a0 = arb_count; c0 = cont_seen; gnt_wait = 3; pend_push = 3;
        run_idle();
        chk(last_hdr == 3, "R2 header length", 64'(last_hdr), 3);
        chk(cont_seen == c0, "R6 no continue", 64'(cont_seen - c0), 0);

        // Packets arriving during data extend the frame.
        a0 = arb_count; c0 = cont_seen; gnt_wait = 1; pend_push = 2;
        repeat (6) tick();
        pend_push = 2;
        run_idle();
        chk(cont_seen - c0 == 1, "R5 continue inserted", 64'(cont_seen - c0), 1);
        chk(arb_count - a0 == 1, "R8 single arbitration", 64'(arb_count - a0), 1);

        // Cap at MAX_BURST.
        c0 = cont_seen; gnt_wait = 0; pend_push = 12;
        run_idle();
        chk(last_hdr == MB, "R7 capped header", 64'(last_hdr), MB);
        chk(cont_seen - c0 == 1, "R7 remainder in continue", 64'(cont_seen - c0), 1);

        // Arrivals while waiting for the grant do not change the header length.
        c0 = cont_seen; gnt_wait = 4; pend_push = 1;
        tick(); tick();
        pend_push = 2;
        run_idle();
        chk(last_hdr == 1, "R4 length latched at header", 64'(last_hdr), 1);
        chk(cont_seen - c0 == 1, "R5 later packets continue", 64'(cont_seen - c0), 1);

        // Steady stream under one grant.
        a0 = arb_count; gnt_wait = 2;
        for (int k = 0; k < 10; k++) begin
            pend_push = 1;
            repeat (4) tick();
        end
        run_idle();
        chk(arb_count - a0 == 1, "R8 stream single arbitration", 64'(arb_count - a0), 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule